// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch-Target Lookahead

This block sits at the front of a 32-bit pipelined core and keeps decode supplied with one instruction per clock. A program counter and its own +4 incrementer drive sequential fetches into a six-entry queue whenever the queue has room. Fetches go out through a single request port with a one-bit channel tag. Up to one sequential fetch and one target fetch may be outstanding at the same time.

When decode takes an instruction and flags it as a branch, a separate adder forms the target (instruction address plus offset) in that same cycle. The block then sends one target fetch, which has priority over sequential fetches, and holds the returned word in a one-entry target buffer. The execute stage later reports the outcome. If the branch was not taken, the target is dropped and the queue carries on unchanged. If it was taken and the target word is already buffered, the queue is replaced by that word at once (one clock). If it was taken and the target word has not arrived, the queue is emptied, the PC restarts at the target and decode sees no valid instruction until the target word lands (three clocks).

A three-state controller governs this. SEQ is plain sequential supply. SEQ goes to LOOK when a branch is captured. LOOK goes back to SEQ on a not-taken outcome or on a taken outcome with a buffered target. LOOK goes to REDIR on a taken outcome without a buffered target. REDIR goes to SEQ when the first refetched word is written to the queue.

Top module: `ifetch_front`

## Requirements
- R1: A synchronous reset empties the queue, so `dec_valid` is low in the first cycle after reset. In that cycle the first request is a sequential fetch (`mem_req_tgt`=0) of the reset-vector address.
- R2: Instructions reach decode in ascending address order, 4 bytes apart, each paired with the word the memory returned for its address.
- R3: The queue never holds more than six entries. While decode stalls, exactly six sequential fetches are accepted and then `mem_req_valid` stays low.
- R4: An entry leaves the queue only when `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, `dec_pc` and `dec_instr` hold.
- R5: When `br_valid` is high during a decode handshake, a target request (`mem_req_tgt`=1) goes out for the address `dec_pc + br_offset`, with `br_offset` taken as a two's-complement byte offset.
- R6: A not-taken outcome (`res_valid`=1, `res_taken`=0) leaves the queued sequential entries in place, and decode continues with the instruction after the branch.
- R7: On a taken outcome whose target word is already buffered, `dec_valid` is high with `dec_pc` equal to the target in the cycle after the resolving edge. Delivery then continues at target+4.
- R8: On a taken outcome whose target word is not buffered, `dec_valid` is low for two cycles after the resolving edge. The target instruction is presented in the third cycle, and delivery then continues sequentially.
- R9: At most one sequential and one target fetch are outstanding. A captured branch produces exactly one target request.
- R10: A response that arrives in the resolving cycle of a taken branch, or later for a request issued before it, is discarded and never reaches decode.
- R11: `br_valid` is ignored while a branch is unresolved. `res_valid` is ignored when no branch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Fetch address |
| mem_req_tgt | output | 1 | 1 = target fetch, 0 = sequential fetch |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_tgt | input | 1 | Channel tag of the response |
| mem_rsp_data | input | 32 | Fetched instruction word |
| dec_valid | output | 1 | Instruction available to decode |
| dec_ready | input | 1 | Decode takes the instruction |
| dec_instr | output | 32 | Instruction word |
| dec_pc | output | 32 | Address of the instruction |
| br_valid | input | 1 | Instruction in the current handshake is a branch |
| br_offset | input | 32 | Branch byte offset, two's complement |
| res_valid | input | 1 | Branch outcome valid |
| res_taken | input | 1 | Branch outcome: taken |

## Verification
The in-RTL assertions check, on every cycle, the limits of the queue and the controller: no write into a full queue, a stable head while decode stalls, an empty queue throughout REDIR, exactly one entry after a buffered-target redirect, and no back-to-back target accepts. Only the bench scenarios can show end-to-end ordering and timing. These include the address sequence seen by decode, the one-clock and three-clock redirect latencies, a not-taken branch that leaves the queue intact, ignored branch and outcome strobes, and the discard of a target word that returns in the resolving cycle.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_SEQ,
        ST_LOOK,
        ST_REDIR
    } fe_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] instr;
    } fe_entry_t;
endpackage

// File: rtl/fetch_queue.sv
module fetch_queue
    import ifq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         load,
    input  fe_entry_t                    load_entry,
    input  logic                         push,
    input  fe_entry_t                    push_entry,
    input  logic                         pop,
    output fe_entry_t                    head,
    output logic [$clog2(DEPTH):0]       count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    fe_entry_t      slots [DEPTH];
    logic [PW-1:0]  rd_q, wr_q;
    logic [CW-1:0]  cnt_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= load ? PW'(1) : '0;
            cnt_q <= load ? CW'(1) : '0;
        end else begin
            if (push) wr_q <= step_ptr(wr_q);
            if (pop)  rd_q <= step_ptr(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (flush && load)  slots[0]    <= load_entry;
        else if (!flush && push) slots[wr_q] <= push_entry;
    end

    assign head  = slots[rd_q];
    assign count = cnt_q;

    // R3: the controller never writes into a full queue without a pop
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> (cnt_q < CW'(DEPTH)));

    // R4: the head entry holds while nothing is taken
    a_r4_head_stable: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !pop && !flush) |=> $stable(head));
endmodule

// File: rtl/fetch_addr.sv
module fetch_addr
    import ifq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_cap,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic [ADDR_W-1:0] br_offset,
    input  logic              seq_adv,
    input  logic              load_hit,
    input  logic              load_miss,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] tgt_pc
);
    localparam int INC = DATA_W / 8;

    logic [ADDR_W-1:0] pc_q, tgt_q, tgt_sum, inc_base, inc_sum;

    // dedicated branch adder, runs alongside decode
    assign tgt_sum  = dec_pc + br_offset;
    // sequential incrementer; on a buffered-target redirect it steps past the target
    assign inc_base = load_hit ? tgt_q : pc_q;
    assign inc_sum  = inc_base + ADDR_W'(INC);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_VEC;
            tgt_q <= '0;
        end else begin
            if (br_cap) tgt_q <= tgt_sum;
            if (load_miss)               pc_q <= tgt_q;
            else if (load_hit || seq_adv) pc_q <= inc_sum;
        end
    end

    assign fetch_pc = pc_q;
    assign tgt_pc   = tgt_q;
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import ifq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dec_fire,
    input  logic                   br_valid,
    input  logic                   res_valid,
    input  logic                   res_taken,
    input  logic [$clog2(DEPTH):0] q_count,
    input  logic [ADDR_W-1:0]      fetch_pc,
    input  logic [ADDR_W-1:0]      tgt_pc,
    input  logic                   mem_req_ready,
    input  logic                   mem_rsp_valid,
    input  logic                   mem_rsp_tgt,
    input  logic [DATA_W-1:0]      mem_rsp_data,
    output logic                   mem_req_valid,
    output logic                   mem_req_tgt,
    output logic                   br_cap,
    output logic                   seq_adv,
    output logic                   load_hit,
    output logic                   load_miss,
    output logic                   q_flush,
    output logic                   q_load,
    output fe_entry_t              q_load_entry,
    output logic                   q_push,
    output fe_entry_t              q_push_entry
);
    localparam int CW = $clog2(DEPTH) + 1;

    fe_state_t         state_q, state_d;
    logic              seq_out_q, seq_drop_q, tgt_pend_q, tgt_out_q, tgt_drop_q, tbuf_v_q;
    logic [DATA_W-1:0] tbuf_q;
    logic [ADDR_W-1:0] seq_addr_q;
    logic              res_now, seq_rsp, tgt_rsp, room, seq_free, tgt_req, seq_req;
    logic              tgt_acc, seq_acc;
    logic [CW:0]       occ;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEQ;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:   if (br_cap) state_d = ST_LOOK;
            ST_LOOK:  if (res_now) state_d = (res_taken && !tbuf_v_q) ? ST_REDIR : ST_SEQ;
            ST_REDIR: if (q_push) state_d = ST_SEQ;
            default:  state_d = ST_SEQ;
        endcase
    end

    // outputs and strobes
    always_comb begin
        br_cap    = dec_fire && br_valid && (state_q == ST_SEQ);
        res_now   = res_valid && (state_q == ST_LOOK);
        load_hit  = res_now && res_taken && tbuf_v_q;
        load_miss = res_now && res_taken && !tbuf_v_q;
        q_flush   = load_hit || load_miss;
        q_load    = load_hit;
        seq_rsp   = mem_rsp_valid && !mem_rsp_tgt;
        tgt_rsp   = mem_rsp_valid && mem_rsp_tgt;
        occ       = {1'b0, q_count} + (CW+1)'(seq_out_q);
        room      = occ < (CW+1)'(DEPTH);
        seq_free  = !seq_out_q || seq_rsp;
        tgt_req   = tgt_pend_q && !tgt_out_q && !res_now;
        seq_req   = seq_free && room && !tgt_pend_q && !q_flush;
        mem_req_valid = tgt_req || seq_req;
        mem_req_tgt   = tgt_req;
        tgt_acc   = tgt_req && mem_req_ready;
        seq_acc   = seq_req && mem_req_ready;
        seq_adv   = seq_acc;
        q_push    = seq_rsp && !seq_drop_q && !q_flush;
        q_push_entry = '{pc: seq_addr_q, instr: mem_rsp_data};
        q_load_entry = '{pc: tgt_pc, instr: tbuf_q};
    end

    // fetch channel bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_out_q  <= 1'b0;
            seq_drop_q <= 1'b0;
            tgt_pend_q <= 1'b0;
            tgt_out_q  <= 1'b0;
            tgt_drop_q <= 1'b0;
            tbuf_v_q   <= 1'b0;
            tbuf_q     <= '0;
            seq_addr_q <= '0;
        end else begin
            if (seq_acc) begin
                seq_out_q  <= 1'b1;
                seq_addr_q <= fetch_pc;
            end else if (seq_rsp) begin
                seq_out_q  <= 1'b0;
            end
            if (q_flush && seq_out_q && !seq_rsp) seq_drop_q <= 1'b1;
            else if (seq_rsp)                     seq_drop_q <= 1'b0;

            if (br_cap)                   tgt_pend_q <= 1'b1;
            else if (tgt_acc || res_now)  tgt_pend_q <= 1'b0;

            if (tgt_acc)      tgt_out_q <= 1'b1;
            else if (tgt_rsp) tgt_out_q <= 1'b0;

            if (res_now && tgt_out_q && !tgt_rsp) tgt_drop_q <= 1'b1;
            else if (tgt_rsp)                     tgt_drop_q <= 1'b0;

            if (res_now || br_cap) begin
                tbuf_v_q <= 1'b0;
            end else if (tgt_rsp && !tgt_drop_q && state_q == ST_LOOK) begin
                tbuf_v_q <= 1'b1;
                tbuf_q   <= mem_rsp_data;
            end
        end
    end

    // R8: the queue stays empty for the whole redirect wait
    a_r8_redir_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REDIR) |-> (q_count == '0));

    // R7: a buffered-target redirect leaves exactly the target in the queue
    a_r7_hit_single: assert property (@(posedge clk) disable iff (rst)
        load_hit |=> (q_count == CW'(1)));

    // R9: target fetches are never accepted on consecutive edges
    a_r9_tgt_spaced: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_tgt && mem_req_ready) |=>
        !(mem_req_valid && mem_req_tgt && mem_req_ready));

    // R10: nothing is written into the queue in the cycle after a miss redirect
    a_r10_miss_clean: assert property (@(posedge clk) disable iff (rst)
        load_miss |=> !q_push);
endmodule

// File: rtl/ifetch_front.sv
module ifetch_front
    import ifq_pkg::*;
#(
    parameter int                DEPTH     = 6,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_tgt,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_tgt,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [DATA_W-1:0] dec_instr,
    output logic [ADDR_W-1:0] dec_pc,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_offset,
    input  logic              res_valid,
    input  logic              res_taken
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]     q_count;
    fe_entry_t         head, q_load_entry, q_push_entry;
    logic              q_flush, q_load, q_push, dec_fire;
    logic              br_cap, seq_adv, load_hit, load_miss;
    logic [ADDR_W-1:0] fetch_pc, tgt_pc;

    assign dec_valid    = (q_count != '0);
    assign dec_fire     = dec_valid && dec_ready;
    assign dec_pc       = head.pc;
    assign dec_instr    = head.instr;
    assign mem_req_addr = mem_req_tgt ? tgt_pc : fetch_pc;

    fetch_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .flush      (q_flush),
        .load       (q_load),
        .load_entry (q_load_entry),
        .push       (q_push),
        .push_entry (q_push_entry),
        .pop        (dec_fire),
        .head       (head),
        .count      (q_count)
    );

    fetch_addr #(.RESET_VEC(RESET_VEC)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .br_cap    (br_cap),
        .dec_pc    (dec_pc),
        .br_offset (br_offset),
        .seq_adv   (seq_adv),
        .load_hit  (load_hit),
        .load_miss (load_miss),
        .fetch_pc  (fetch_pc),
        .tgt_pc    (tgt_pc)
    );

    fetch_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .dec_fire      (dec_fire),
        .br_valid      (br_valid),
        .res_valid     (res_valid),
        .res_taken     (res_taken),
        .q_count       (q_count),
        .fetch_pc      (fetch_pc),
        .tgt_pc        (tgt_pc),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_tgt   (mem_rsp_tgt),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_tgt   (mem_req_tgt),
        .br_cap        (br_cap),
        .seq_adv       (seq_adv),
        .load_hit      (load_hit),
        .load_miss     (load_miss),
        .q_flush       (q_flush),
        .q_load        (q_load),
        .q_load_entry  (q_load_entry),
        .q_push        (q_push),
        .q_push_entry  (q_push_entry)
    );
endmodule

// File: tb/ifetch_front_test.sv
module ifetch_front_test;
    localparam logic [31:0] RVEC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req_valid, mem_req_tgt, mem_rsp_valid, mem_rsp_tgt;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic        dec_valid, dec_ready = 1'b0;
    logic [31:0] dec_instr, dec_pc;
    logic        br_valid, br_arm = 1'b0;
    logic [31:0] br_at = '0, br_off = '0;
    logic        res_valid = 1'b0, res_taken = 1'b0;

    int checks = 0, errors = 0, seen = 0;
    int seq_n = 0, tgt_n = 0;
    logic [31:0] first_addr = '0, last_tgt = '0;
    logic        first_tgt = 1'b0, have_first = 1'b0;
    logic [31:0] exp_q [$];
    string       cur_req = "R2";

    always #10 clk = ~clk;

    assign br_valid = br_arm && dec_valid && (dec_pc == br_at);

    ifetch_front #(.RESET_VEC(RVEC)) uut (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tgt(mem_req_tgt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tgt(mem_rsp_tgt),
        .mem_rsp_data(mem_rsp_data),
        .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_instr(dec_instr), .dec_pc(dec_pc),
        .br_valid(br_valid), .br_offset(br_off),
        .res_valid(res_valid), .res_taken(res_taken)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3C3_0000;
    endfunction

    // memory model: one-cycle response
    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_tgt   <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_ready;
            mem_rsp_tgt   <= mem_req_tgt;
            mem_rsp_data  <= word_at(mem_req_addr);
            if (mem_req_valid && mem_ready) begin
                if (!have_first) begin
                    have_first <= 1'b1;
                    first_addr <= mem_req_addr;
                    first_tgt  <= mem_req_tgt;
                end
                if (mem_req_tgt) begin
                    tgt_n    <= tgt_n + 1;
                    last_tgt <= mem_req_addr;
                end else begin
                    seq_n <= seq_n + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard compare on every decode handshake
    always @(negedge clk) begin
        if (!rst && dec_valid && dec_ready) begin
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected instruction pc", dec_pc, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(dec_pc == e, cur_req, "decode pc", dec_pc, e);
                check(dec_instr == word_at(e), cur_req, "decode word", dec_instr, word_at(e));
            end
        end
    end

    task automatic expect_run(input logic [31:0] start, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(start + 32'(4 * i));
    endtask

    task automatic consume(input int n);
        int goal;
        goal = seen + n;
        dec_ready = 1'b1;
        while (seen < goal) @(posedge clk);
        #2;
        dec_ready = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic resolve(input bit tk);
        res_valid = 1'b1;
        res_taken = tk;
        @(posedge clk);
        #2;
        res_valid = 1'b0;
        res_taken = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(dec_valid == 1'b0, "R1", "dec_valid after reset", 32'(dec_valid), 32'h0);
        check(mem_req_valid && !mem_req_tgt && mem_req_addr == RVEC, "R1",
              "first request", mem_req_addr, RVEC);
        @(posedge clk); #2;

        // R3/R4: decode stalled, queue fills to six and stops fetching
        step(20);
        check(seq_n == 6, "R3", "accepted fetches while stalled", 32'(seq_n), 32'd6);
        check(mem_req_valid == 1'b0, "R3", "request while full", 32'(mem_req_valid), 32'h0);
        check(dec_valid && dec_pc == RVEC, "R4", "head while stalled", dec_pc, RVEC);
        step(3);
        check(dec_pc == RVEC && dec_instr == word_at(RVEC), "R4", "head hold", dec_pc, RVEC);

        // R2: sequential stream
        cur_req = "R2";
        expect_run(RVEC, 10);
        consume(10);

        // R5/R9/R11/R6: branch at 0x1030, not taken
        cur_req = "R5";
        br_at = 32'h1030; br_off = 32'h100; br_arm = 1'b1;
        expect_run(32'h1028, 3);
        consume(3);
        step(3);
        check(tgt_n == 1, "R9", "target requests per branch", 32'(tgt_n), 32'd1);
        check(last_tgt == 32'h1130, "R5", "target address", last_tgt, 32'h1130);
        cur_req = "R11";
        br_at = 32'h1038; br_off = 32'h300;
        expect_run(32'h1034, 2);
        consume(2);
        br_arm = 1'b0;
        check(tgt_n == 1, "R11", "branch ignored while pending", 32'(tgt_n), 32'd1);
        resolve(1'b0);
        cur_req = "R6";
        expect_run(32'h103C, 3);
        consume(3);

        // R11: outcome with no branch pending is ignored
        resolve(1'b1);
        @(negedge clk);
        check(dec_valid && dec_pc == 32'h1048, "R11", "queue after stray outcome",
              dec_pc, 32'h1048);
        @(posedge clk); #2;
        cur_req = "R11";
        expect_run(32'h1048, 2);
        consume(2);

        // R7: taken with buffered target
        cur_req = "R7";
        br_at = 32'h1050; br_off = 32'h200; br_arm = 1'b1;
        expect_run(32'h1050, 1);
        consume(1);
        br_arm = 1'b0;
        step(4);
        resolve(1'b1);
        @(negedge clk);
        check(dec_valid && dec_pc == 32'h1250, "R7", "target one clock after",
              dec_pc, 32'h1250);
        @(posedge clk); #2;
        expect_run(32'h1250, 4);
        consume(4);

        // R8: taken, target not fetched (memory stalled), negative offset
        cur_req = "R8";
        step(3);
        mem_ready = 1'b0;
        step(1);
        br_at = 32'h1260; br_off = 32'hFFFF_FFA0; br_arm = 1'b1;
        expect_run(32'h1260, 1);
        consume(1);
        br_arm = 1'b0;
        mem_ready = 1'b1;
        resolve(1'b1);
        @(negedge clk);
        check(dec_valid == 1'b0, "R8", "valid 1 cycle after miss", 32'(dec_valid), 32'h0);
        @(negedge clk);
        check(dec_valid == 1'b0, "R8", "valid 2 cycles after miss", 32'(dec_valid), 32'h0);
        @(negedge clk);
        check(dec_valid && dec_pc == 32'h1200, "R8", "target third cycle", dec_pc, 32'h1200);
        @(posedge clk); #2;
        expect_run(32'h1200, 3);
        consume(3);

        // R10: target word returns in the resolving cycle and is discarded
        cur_req = "R10";
        step(2);
        br_at = 32'h120C; br_off = 32'h400; br_arm = 1'b1;
        expect_run(32'h120C, 1);
        consume(1);
        br_arm = 1'b0;
        step(1);
        resolve(1'b1);
        @(negedge clk);
        check(dec_valid == 1'b0, "R10", "no stale word after flush", 32'(dec_valid), 32'h0);
        @(negedge clk);
        @(negedge clk);
        check(dec_valid && dec_pc == 32'h160C, "R10", "refetched target", dec_pc, 32'h160C);
        @(posedge clk); #2;
        expect_run(32'h160C, 2);
        consume(2);
        check(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule